// File: doc/BRIEF.md
# Legacy Memory Window Attribute Decoder

This block sits between the CPU's memory request path and the memory controller. For every access it decides whether the access goes to main DRAM or is forwarded to the I/O bus. For writes, it also decides whether the write is permitted. The decision applies only to the legacy window from 0xA0000 to 0xFFFFF. Any address outside that window is handed to DRAM unchanged.

The window is divided into three kinds of region:

- **Upper 64 KB block (0xF0000–0xFFFFF).** It uses one two-bit attribute.
- **Twelve 16 KB segments starting at 0xC0000.** Each uses its own two-bit attribute. The attributes are packed two per configuration byte.
- **128 KB display window (0xA0000–0xBFFFF).** Its routing depends on a system-management control byte and on the system-management-mode input.

All control bytes are written through a simple byte-wide configuration port. A configuration write takes effect from the clock edge that captures it. The access decode itself is purely combinational from the access address, the read/write flag, the mode input and the registered configuration. A change of the mode input therefore acts on the access presented in the same cycle.

Top module: `legacy_window_decoder`

## Requirements
- R1: After reset every attribute is 0 and the control byte at 0x72 holds 0x02. Every read or write inside 0xA0000–0xFFFFF then gives to_dram=0 and wr_allowed=1.
- R2: Any access below 0xA0000 or at or above 0x100000 gives to_dram=1 and wr_allowed=1, whatever the configuration.
- R3: The block 0xF0000–0xFFFFF takes its attribute from bits [5:4] of configuration byte 0x59.
- R4: Segment i covers 0xC0000 + i*0x4000 up to the next segment, for i = 0 to 11. Its attribute is held in byte 0x5A + (i div 2): bits [1:0] for even i and bits [5:4] for odd i.
- R5: Attribute bit 0 sends reads to DRAM, and attribute bit 1 sends writes to DRAM. Value 3 routes both, 1 routes reads only, 2 routes writes only, and 0 forwards both to the I/O bus.
- R6: A write to a region whose attribute is 1 gives wr_allowed=0. Every other access gives wr_allowed=1.
- R7: Accesses to 0xA0000–0xBFFFF give to_dram=1 exactly when control-byte bit 6 is set, or when smm_active=1 and control-byte bit 3 is set. wr_allowed is 1 there.
- R8: A configuration write to 0x59–0x5F or 0x72 changes the decode from the cycle after its capturing edge. A change of smm_active changes the decode in the same cycle.
- R9: Configuration writes to any other address leave every decode unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| smm_active | input | 1 | System-management mode is active |
| acc_addr | input | 32 | Physical address of the current access |
| acc_write | input | 1 | 1 for a write access, 0 for a read |
| to_dram | output | 1 | Route the access to DRAM (0 = forward to the I/O bus) |
| wr_allowed | output | 1 | The write may proceed |

## Verification
On every cycle the assertions check four things:

- Out-of-window addresses pass through to DRAM.
- A blocked write is always a write that is not routed to DRAM.
- The display window follows the control byte's bit 6.
- Control-byte writes land one cycle later.

Only the bench's scenarios can show that each segment reads the correct nibble of the correct byte, that every edge address falls into the right segment, and that all four attribute values mean what R5 says. The same holds for the SMM-and-bit-3 combination and for ignored configuration addresses.

// File: rtl/lwd_pkg.sv
package lwd_pkg;

  localparam int ADDR_W   = 32;
  localparam int CFG_W    = 8;
  localparam int NUM_SEG  = 12;
  localparam int SEG_SHIFT = 14;
  localparam int SEG_IDX_W = $clog2(NUM_SEG);
  localparam int SEG_BYTES = NUM_SEG / 2;

  localparam logic [ADDR_W-1:0] WIN_LO   = 32'h000A_0000;
  localparam logic [ADDR_W-1:0] SEG_LO   = 32'h000C_0000;
  localparam logic [ADDR_W-1:0] HIGH_LO  = 32'h000F_0000;
  localparam logic [ADDR_W-1:0] WIN_END  = 32'h0010_0000;

  localparam logic [CFG_W-1:0] HIGH_CFG_ADDR = 8'h59;
  localparam logic [CFG_W-1:0] SEG_CFG_BASE  = 8'h5A;
  localparam logic [CFG_W-1:0] SMRAM_ADDR    = 8'h72;
  localparam logic [CFG_W-1:0] SMRAM_RESET   = 8'h02;
  localparam int SMRAM_SMM_BIT  = 3;
  localparam int SMRAM_OPEN_BIT = 6;

  typedef enum logic [1:0] {
    RGN_OUTSIDE = 2'd0,
    RGN_DISPLAY = 2'd1,
    RGN_SEGMENT = 2'd2,
    RGN_HIGH    = 2'd3
  } region_e;

  typedef struct packed {
    logic to_dram;
    logic wr_ok;
  } route_t;

  function automatic region_e classify(input logic [ADDR_W-1:0] a);
    if (a < WIN_LO || a >= WIN_END) return RGN_OUTSIDE;
    if (a < SEG_LO)                 return RGN_DISPLAY;
    if (a < HIGH_LO)                return RGN_SEGMENT;
    return RGN_HIGH;
  endfunction

  function automatic logic [SEG_IDX_W-1:0] seg_index(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] off;
    off = (a - SEG_LO) >> SEG_SHIFT;
    return off[SEG_IDX_W-1:0];
  endfunction

  // Two-bit attribute out of a packed byte: low nibble for even, high for odd.
  function automatic logic [1:0] nibble_attr(input logic [CFG_W-1:0] b, input logic odd);
    return odd ? b[5:4] : b[1:0];
  endfunction

  // bit0: reads to DRAM, bit1: writes to DRAM; attribute 1 blocks writes.
  function automatic route_t apply_attr(input logic [1:0] attr, input logic wr);
    route_t r;
    r.to_dram = wr ? attr[1] : attr[0];
    r.wr_ok   = !(wr && attr == 2'b01);
    return r;
  endfunction

endpackage

// File: rtl/lwd_cfg_regs.sv
module lwd_cfg_regs
  import lwd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [CFG_W-1:0]     cfg_addr,
  input  logic [CFG_W-1:0]     cfg_wdata,
  output logic [NUM_SEG-1:0][1:0] seg_attr,
  output logic [1:0]           high_attr,
  output logic [CFG_W-1:0]     smram_q
);

  logic [CFG_W-1:0] high_q;
  logic [SEG_BYTES-1:0][CFG_W-1:0] seg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      high_q  <= '0;
      smram_q <= SMRAM_RESET;
    end else if (cfg_we) begin
      if (cfg_addr == HIGH_CFG_ADDR) high_q  <= cfg_wdata;
      if (cfg_addr == SMRAM_ADDR)    smram_q <= cfg_wdata;
    end
  end

  for (genvar k = 0; k < SEG_BYTES; k++) begin : g_seg_byte
    localparam logic [CFG_W-1:0] MY_ADDR = SEG_CFG_BASE + CFG_W'(k);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               seg_q[k] <= '0;
      else if (cfg_we && cfg_addr == MY_ADDR)   seg_q[k] <= cfg_wdata;
    end
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg_attr
    assign seg_attr[s] = nibble_attr(seg_q[s/2], 1'((s % 2)));
  end

  assign high_attr = high_q[5:4];

  // R8
  smram_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == SMRAM_ADDR) |=> (smram_q == $past(cfg_wdata)));

endmodule

// File: rtl/lwd_region_decode.sv
module lwd_region_decode
  import lwd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    acc_addr,
  input  logic                 acc_write,
  input  logic                 smm_active,
  input  logic [NUM_SEG-1:0][1:0] seg_attr,
  input  logic [1:0]           high_attr,
  input  logic [CFG_W-1:0]     smram_q,
  output logic                 to_dram,
  output logic                 wr_allowed,
  output logic                 in_window,
  output logic                 display_hit
);

  region_e          rgn;
  logic [SEG_IDX_W-1:0] sidx;
  logic [1:0]       attr;
  route_t           rt;
  logic             display_open;

  assign rgn         = classify(acc_addr);
  assign sidx        = seg_index(acc_addr);
  assign in_window   = (rgn != RGN_OUTSIDE);
  assign display_hit = (rgn == RGN_DISPLAY);
  assign display_open = smram_q[SMRAM_OPEN_BIT] ||
                        (smm_active && smram_q[SMRAM_SMM_BIT]);

  always_comb begin
    attr = 2'b00;
    if (rgn == RGN_HIGH) attr = high_attr;
    else if (rgn == RGN_SEGMENT && int'(sidx) < NUM_SEG) attr = seg_attr[sidx];
  end

  assign rt = apply_attr(attr, acc_write);

  always_comb begin
    unique case (rgn)
      RGN_OUTSIDE: begin to_dram = 1'b1;         wr_allowed = 1'b1; end
      RGN_DISPLAY: begin to_dram = display_open; wr_allowed = 1'b1; end
      default:     begin to_dram = rt.to_dram;   wr_allowed = rt.wr_ok; end
    endcase
  end

  // R2
  outside_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_window |-> (to_dram && wr_allowed));

  // R6
  blocked_is_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_allowed |-> (acc_write && !to_dram && in_window && !display_hit));

endmodule

// File: rtl/legacy_window_decoder.sv
module legacy_window_decoder
  import lwd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              smm_active,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  output logic              to_dram,
  output logic              wr_allowed
);

  logic [NUM_SEG-1:0][1:0] seg_attr;
  logic [1:0]              high_attr;
  logic [CFG_W-1:0]        smram_q;
  logic                    in_window;
  logic                    display_hit;

  lwd_cfg_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .seg_attr  (seg_attr),
    .high_attr (high_attr),
    .smram_q   (smram_q)
  );

  lwd_region_decode u_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_addr    (acc_addr),
    .acc_write   (acc_write),
    .smm_active  (smm_active),
    .seg_attr    (seg_attr),
    .high_attr   (high_attr),
    .smram_q     (smram_q),
    .to_dram     (to_dram),
    .wr_allowed  (wr_allowed),
    .in_window   (in_window),
    .display_hit (display_hit)
  );

  // R7
  display_open_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (display_hit && smram_q[SMRAM_OPEN_BIT]) |-> (to_dram && wr_allowed));

endmodule

// File: tb/legacy_window_decoder_test.sv
module legacy_window_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        smm_active = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic        to_dram, wr_allowed;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  legacy_window_decoder uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .smm_active(smm_active), .acc_addr(acc_addr),
    .acc_write(acc_write), .to_dram(to_dram), .wr_allowed(wr_allowed)
  );

  // {cfg_en, cfg_addr, cfg_data, smm, write, addr[19:0], exp_dram, exp_wr_ok}
  localparam int NV = 16;
  localparam logic [40:0] VEC [NV] = '{
    {1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 20'hC0000, 1'b0, 1'b1}, // R1
    {1'b1, 8'h5A, 8'h31, 1'b0, 1'b0, 20'hC0000, 1'b1, 1'b1}, // R4 seg0=1
    {1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 20'hC0000, 1'b0, 1'b0}, // R6
    {1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 20'hC4000, 1'b1, 1'b1}, // R4 seg1=3
    {1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 20'hC7FFF, 1'b1, 1'b1}, // R5
    {1'b1, 8'h59, 8'h20, 1'b0, 1'b0, 20'hF0000, 1'b0, 1'b1}, // R3 attr2 read
    {1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 20'hFFFFF, 1'b1, 1'b1}, // R3 attr2 write
    {1'b1, 8'h5F, 8'h12, 1'b0, 1'b1, 20'hE8000, 1'b1, 1'b1}, // R4 seg10=2
    {1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 20'hEC000, 1'b1, 1'b1}, // R4 seg11=1
    {1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 20'hEFFFF, 1'b0, 1'b0}, // R6
    {1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 20'hA0000, 1'b0, 1'b1}, // R7 closed
    {1'b1, 8'h72, 8'h0A, 1'b0, 1'b0, 20'hBFFFF, 1'b0, 1'b1}, // R7 bit3 no smm
    {1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 20'hB0000, 1'b1, 1'b1}, // R8 smm same cycle
    {1'b1, 8'h72, 8'h42, 1'b0, 1'b1, 20'hA0000, 1'b1, 1'b1}, // R7 bit6
    {1'b1, 8'h60, 8'hFF, 1'b0, 1'b0, 20'h9FFFF, 1'b1, 1'b1}, // R2
    {1'b1, 8'h58, 8'hFF, 1'b0, 1'b0, 20'hF0000, 1'b0, 1'b1}  // R9
  };

  logic [7:0] shadow [256];

  task automatic check(input string tag, input logic exp_d, input logic exp_w);
    n_checks++;
    if (to_dram !== exp_d || wr_allowed !== exp_w) begin
      n_fail++;
      $display("FAIL %s addr=%h wr=%0d: got dram=%b wok=%b expected dram=%b wok=%b",
               tag, acc_addr, acc_write, to_dram, wr_allowed, exp_d, exp_w);
    end
  endtask

  task automatic cfg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    shadow[a] = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input logic [31:0] a, input logic wr, input logic smm);
    acc_addr = a; acc_write = wr; smm_active = smm;
    #2;
  endtask

  // Expected route for a PAM-style attribute, from R5/R6.
  function automatic logic [1:0] attr_expect(input int attr, input logic wr);
    logic d, w;
    case (attr)
      3: begin d = 1'b1; w = 1'b1; end
      2: begin d = wr;   w = 1'b1; end
      1: begin d = !wr;  w = !wr;  end
      default: begin d = 1'b0; w = 1'b1; end
    endcase
    return {d, w};
  endfunction

  initial begin
    #(20ns * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [1:0] e;
    for (int i = 0; i < 256; i++) shadow[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state across the whole window
    for (int a = 'hA0000; a < 'h100000; a += 'h4000) begin
      access(32'(a), 1'b0, 1'b0); check("R1 read", 1'b0, 1'b1);
      access(32'(a), 1'b1, 1'b0); check("R1 write", 1'b0, 1'b1);
    end

    // Table walk
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][40]) cfg(VEC[v][39:32], VEC[v][31:24]);
      else @(negedge clk);
      access({12'h000, VEC[v][21:2]}, VEC[v][22], VEC[v][23]);
      check($sformatf("table v%0d", v), VEC[v][1], VEC[v][0]);
    end

    // R4/R5: sweep every segment, every attribute, both edges
    cfg(8'h59, 8'h00);
    for (int k = 0; k < 6; k++) cfg(8'h5A + 8'(k), 8'h00);
    for (int s = 0; s < 12; s++) begin
      for (int at = 0; at < 4; at++) begin
        int byte_a;
        byte_a = 'h5A + s / 2;
        cfg(8'(byte_a), (s % 2 == 1) ? 8'(at << 4) : 8'(at));
        for (int wr = 0; wr < 2; wr++) begin
          e = attr_expect(at, wr[0]);
          access(32'h000C_0000 + 32'(s) * 32'h4000, wr[0], 1'b0);
          check("R4 seg start", e[1], e[0]);
          access(32'h000C_0000 + 32'(s + 1) * 32'h4000 - 1, wr[0], 1'b0);
          check("R4 seg end", e[1], e[0]);
          if (s < 11) begin
            access(32'h000C_0000 + 32'(s + 1) * 32'h4000, wr[0], 1'b0);
            check("R4 neighbour", 1'b0, 1'b1);
          end
        end
      end
      cfg(8'('h5A + s / 2), 8'h00);
    end

    // R3: high block, all attributes; low nibble bits must not matter
    for (int at = 0; at < 4; at++) begin
      cfg(8'h59, 8'(at << 4) | 8'h0F);
      for (int wr = 0; wr < 2; wr++) begin
        e = attr_expect(at, wr[0]);
        access(32'h000F_8000, wr[0], 1'b0);
        check("R3 high", e[1], e[0]);
      end
    end

    // R7/R8: display window over SMM and control bits
    for (int c = 0; c < 4; c++) begin
      cfg(8'h72, 8'h02 | (c[0] ? 8'h08 : 8'h00) | (c[1] ? 8'h40 : 8'h00));
      for (int m = 0; m < 2; m++) begin
        access(32'h000A_8000, 1'b1, m[0]);
        check("R7 display", c[1] | (c[0] & m[0]), 1'b1);
      end
    end

    // R8: write visible only after the capturing edge
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 8'h72; cfg_wdata = 8'h00;
    access(32'h000A_0000, 1'b0, 1'b0);
    check("R8 before edge", 1'b1, 1'b1);
    @(negedge clk);
    cfg_we = 1'b0;
    #2;
    check("R8 after edge", 1'b0, 1'b1);

    // R2: edges of the window
    access(32'h0009_FFFF, 1'b1, 1'b0); check("R2 below", 1'b1, 1'b1);
    access(32'h0010_0000, 1'b1, 1'b0); check("R2 above", 1'b1, 1'b1);
    access(32'hFFFF_FFFF, 1'b0, 1'b1); check("R2 top", 1'b1, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule